// File: doc/BRIEF.md
# Medium-Rate Infrared Frame Receiver

This block takes one synchronous infrared receive line and turns it into a stream of frame bytes. An external divider supplies a sample strobe that fires a fixed number of times per bit period (four by default). Within each bit period the block looks for a light pulse. A pulse means a 0 bit and a dark period means a 1 bit. After that, the block works at the bit-stuffed framing layer: it finds the flag octet, drops the zero inserted after every run of five ones, detects aborts, packs bits least-significant first into bytes, and checks a 16-bit frame check sequence.

Downstream logic sees only payload bytes. Each byte comes with a valid strobe. The last payload byte of a frame also carries an end-of-frame marker and an error bit. The error bit reports a failed check sequence or a frame that did not end on a byte boundary. The two check-sequence bytes are held back and never appear at the output. An aborted frame ends with no end-of-frame marker.

Top module: `mir_rx`

## Requirements
- R1: A sample window of OSR strobes that contains a high sample on `ir_rx_i` decodes as bit 0. A window with no high sample decodes as bit 1. Bits fill each byte starting at bit 0.
- R2: Inside a frame, a 0 that follows exactly five consecutive 1s is removed from the data.
- R3: The octet 01111110 opens or closes a frame and is never output as data. Idle line time and back-to-back flags produce no output. A payload byte of value 0x7E passes through unharmed.
- R4: The last two bytes before a closing flag are the check sequence and are never output. A frame with fewer than one payload byte produces no output.
- R5: `eof_o` is high together with `valid_o` on the last payload byte of a frame, and on no other byte.
- R6: A CRC-16 (reflected polynomial 0x8408, seed 0xFFFF) runs over payload plus check bytes, the check bytes being sent low byte first. A residue of 0xF0B8 gives `err_o`=0 on the end-of-frame byte. Any other residue gives `err_o`=1. `err_o` is never high without `eof_o`.
- R7: Seven consecutive 1s inside a frame abort it. Bytes still held back are dropped, no `eof_o` is produced, and the next frame decodes normally.
- R8: If the number of unstuffed bits between the flags is not a multiple of eight, `err_o` is set on the end-of-frame byte.
- R9: The bit phase realigns to the rising edge of each pulse. A frame in which every zero bit lasts OSR-1 or OSR+1 strobes still decodes without error.
- R10: After reset `valid_o`, `eof_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_en_i | input | 1 | Oversampling strobe, OSR per bit period |
| ir_rx_i | input | 1 | Receive line, high while a pulse is present |
| data_o | output | 8 | Payload byte |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| eof_o | output | 1 | Marks the last payload byte of a frame |
| err_o | output | 1 | Frame failed its check or length test; valid with `eof_o` |

## Verification
The hardest condition to reach is a bit period whose length differs from nominal. Such a period can only arise when the pulse edge arrives at an unexpected phase. The bench forces it by stretching or shrinking every zero-bit period by one strobe across a whole sweep of frame lengths and payload patterns, including all-ones and flag-valued payloads that exercise stuffing. Aborts, corrupted check bytes and misaligned bit counts are also built from the line level, so that every path through the deframer is driven at the ports.

// File: rtl/mir_rx_pkg.sv
package mir_rx_pkg;
  localparam int BYTE_W      = 8;
  localparam int CRC_W       = 16;
  localparam int FCS_BYTES   = CRC_W / BYTE_W;
  localparam int HOLD_BYTES  = FCS_BYTES + 1;
  localparam logic [CRC_W-1:0] CRC_POLY    = 16'h8408;
  localparam logic [CRC_W-1:0] CRC_SEED    = 16'hFFFF;
  localparam logic [CRC_W-1:0] CRC_RESIDUE = 16'hF0B8;

  function automatic logic [CRC_W-1:0] crc_byte(logic [CRC_W-1:0] c, logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int i = 0; i < BYTE_W; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/mir_demod.sv
module mir_demod #(
  parameter int OSR = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_en_i,
  input  logic rx_i,
  output logic bit_stb_o,
  output logic bit_o
);
  localparam int PH_W = (OSR > 2) ? $clog2(OSR) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(OSR / 2);

  logic [PH_W-1:0] phase_q;
  logic            seen_q;
  logic            prev_q;
  logic            rise;

  assign rise = rx_i & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= '0;
      seen_q    <= 1'b0;
      prev_q    <= 1'b0;
      bit_stb_o <= 1'b0;
      bit_o     <= 1'b1;
    end else begin
      bit_stb_o <= 1'b0;
      if (smp_en_i) begin
        prev_q <= rx_i;
        if (rise && phase_q >= PH_HALF) begin
          // early edge: close current period, edge starts the next one
          bit_stb_o <= 1'b1;
          bit_o     <= ~seen_q;
          seen_q    <= 1'b1;
          phase_q   <= PH_W'(1);
        end else if (rise) begin
          // late or on-time edge: realign within current period
          seen_q  <= 1'b1;
          phase_q <= PH_W'(1);
        end else if (phase_q == PH_LAST) begin
          bit_stb_o <= 1'b1;
          bit_o     <= ~(seen_q | rx_i);
          seen_q    <= 1'b0;
          phase_q   <= '0;
        end else begin
          seen_q  <= seen_q | rx_i;
          phase_q <= phase_q + PH_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mir_deframe.sv
module mir_deframe
  import mir_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              bit_i,
  output logic              byte_stb_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              close_o,
  output logic              len_ok_o,
  output logic              abort_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [2:0]        ones_q;
  logic              in_frame_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic [BYTE_W-1:0] sh_nxt;
  logic              push, flag, abrt;

  assign sh_nxt = {bit_i, sh_q[BYTE_W-1:1]};
  assign flag   = bit_stb_i & ~bit_i & (ones_q == 3'd6);
  assign abrt   = bit_stb_i &  bit_i & (ones_q == 3'd6) & in_frame_q;
  assign push   = bit_stb_i & in_frame_q &
                  (bit_i ? (ones_q < 3'd6) : (ones_q != 3'd6 && ones_q != 3'd5));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q     <= 3'd7;
      in_frame_q <= 1'b0;
      sh_q       <= '0;
      bcnt_q     <= '0;
      byte_stb_o <= 1'b0;
      byte_o     <= '0;
      close_o    <= 1'b0;
      len_ok_o   <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      byte_stb_o <= 1'b0;
      close_o    <= 1'b0;
      abort_o    <= 1'b0;
      if (bit_stb_i) begin
        if (!bit_i)                ones_q <= 3'd0;
        else if (ones_q != 3'd7)   ones_q <= ones_q + 3'd1;
      end
      if (push) begin
        sh_q   <= sh_nxt;
        bcnt_q <= bcnt_q + CNT_W'(1);
        if (bcnt_q == CNT_W'(BYTE_W - 1)) begin
          byte_stb_o <= 1'b1;
          byte_o     <= sh_nxt;
        end
      end
      if (flag) begin
        // seven flag bits (0 + six 1s) were shifted in already
        close_o    <= 1'b1;
        len_ok_o   <= (bcnt_q == CNT_W'(BYTE_W - 1));
        in_frame_q <= 1'b1;
        bcnt_q     <= '0;
      end
      if (abrt) begin
        abort_o    <= 1'b1;
        in_frame_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mir_fcs.sv
module mir_fcs
  import mir_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_stb_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              close_i,
  input  logic              len_ok_i,
  input  logic              abort_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              eof_o,
  output logic              err_o
);
  localparam int HC_W = $clog2(HOLD_BYTES + 1);
  localparam logic [HC_W-1:0] HC_FULL = HC_W'(HOLD_BYTES);

  logic [BYTE_W-1:0] hold_q [HOLD_BYTES];
  logic [HC_W-1:0]   cnt_q;
  logic [CRC_W-1:0]  crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HOLD_BYTES; i++) hold_q[i] <= '0;
      cnt_q   <= '0;
      crc_q   <= CRC_SEED;
      data_o  <= '0;
      valid_o <= 1'b0;
      eof_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      eof_o   <= 1'b0;
      err_o   <= 1'b0;
      if (abort_i) begin
        cnt_q <= '0;
        crc_q <= CRC_SEED;
      end else if (close_i) begin
        if (cnt_q == HC_FULL) begin
          valid_o <= 1'b1;
          data_o  <= hold_q[0];
          eof_o   <= 1'b1;
          err_o   <= !len_ok_i || (crc_q != CRC_RESIDUE);
        end
        cnt_q <= '0;
        crc_q <= CRC_SEED;
      end else if (byte_stb_i) begin
        crc_q <= crc_byte(crc_q, byte_i);
        if (cnt_q == HC_FULL) begin
          valid_o <= 1'b1;
          data_o  <= hold_q[0];
          for (int i = 0; i < HOLD_BYTES - 1; i++) hold_q[i] <= hold_q[i+1];
          hold_q[HOLD_BYTES-1] <= byte_i;
        end else begin
          for (int i = 0; i < HOLD_BYTES; i++)
            if (cnt_q == HC_W'(i)) hold_q[i] <= byte_i;
          cnt_q <= cnt_q + HC_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mir_rx.sv
module mir_rx
  import mir_rx_pkg::*;
#(
  parameter int OSR = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_en_i,
  input  logic              ir_rx_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              eof_o,
  output logic              err_o
);
  logic              bit_stb, bit_val;
  logic              byte_stb, close_stb, len_ok, abort_stb;
  logic [BYTE_W-1:0] byte_val;

  mir_demod #(.OSR(OSR)) u_demod (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_en_i  (smp_en_i),
    .rx_i      (ir_rx_i),
    .bit_stb_o (bit_stb),
    .bit_o     (bit_val)
  );

  mir_deframe u_deframe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_stb_i  (bit_stb),
    .bit_i      (bit_val),
    .byte_stb_o (byte_stb),
    .byte_o     (byte_val),
    .close_o    (close_stb),
    .len_ok_o   (len_ok),
    .abort_o    (abort_stb)
  );

  mir_fcs u_fcs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .byte_stb_i (byte_stb),
    .byte_i     (byte_val),
    .close_i    (close_stb),
    .len_ok_i   (len_ok),
    .abort_i    (abort_stb),
    .data_o     (data_o),
    .valid_o    (valid_o),
    .eof_o      (eof_o),
    .err_o      (err_o)
  );
endmodule

// File: rtl/mir_rx_chk.sv
module mir_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic smp_en_i,
  input logic bit_stb_i,
  input logic byte_stb_i,
  input logic close_i,
  input logic abort_i,
  input logic valid_i,
  input logic eof_i,
  input logic err_i
);
  AST_BIT_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni) bit_stb_i |=> !bit_stb_i); // R1
  AST_ONE_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0({byte_stb_i, close_i, abort_i})); // R3
  AST_EOF_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni) eof_i |-> valid_i); // R5
  AST_ERR_AT_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni) err_i |-> eof_i); // R6
  AST_ABORT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni) abort_i |=> !valid_i); // R7
  AST_BIT_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni) bit_stb_i |-> $past(smp_en_i)); // R9
endmodule

bind mir_rx mir_rx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_en_i   (smp_en_i),
  .bit_stb_i  (bit_stb),
  .byte_stb_i (byte_stb),
  .close_i    (close_stb),
  .abort_i    (abort_stb),
  .valid_i    (valid_o),
  .eof_i      (eof_o),
  .err_i      (err_o)
);

// File: tb/mir_rx_tb.sv
module mir_rx_tb;
  localparam int OSR = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_en = 1'b0;
  logic       ir = 1'b0;
  logic [7:0] data;
  logic       valid, eof, err;

  mir_rx #(.OSR(OSR)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .smp_en_i (smp_en),
    .ir_rx_i  (ir),
    .data_o   (data),
    .valid_o  (valid),
    .eof_o    (eof),
    .err_o    (err)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int zero_len = OSR;
  int ones_run = 0;
  int out_n = 0;
  logic [7:0] cap_d [32];
  logic       cap_e [32];
  logic       cap_r [32];

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (out_n < 32) begin
        cap_d[out_n] = data;
        cap_e[out_n] = eof;
        cap_r[out_n] = err;
      end
      out_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] != d[i]) r = (r >> 1) ^ 16'h8408;
      else              r = r >> 1;
    end
    return r;
  endfunction

  task automatic put_smp(input bit v);
    @(negedge clk);
    ir = v;
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
  endtask

  task automatic send_bit(input bit b);
    if (b) repeat (OSR) put_smp(1'b0);
    else begin
      put_smp(1'b1);
      repeat (zero_len - 1) put_smp(1'b0);
    end
  endtask

  task automatic send_data_bit(input bit b);
    send_bit(b);
    if (b) begin
      ones_run++;
      if (ones_run == 5) begin
        send_bit(1'b0);
        ones_run = 0;
      end
    end else ones_run = 0;
  endtask

  task automatic send_byte(input logic [7:0] d);
    for (int i = 0; i < 8; i++) send_data_bit(d[i]);
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    repeat (6) send_bit(1'b1);
    send_bit(1'b0);
    ones_run = 0;
  endtask

  task automatic send_idle(input int n);
    repeat (n) send_bit(1'b1);
  endtask

  function automatic logic [7:0] pay_of(input int kind, input int len, input int i);
    if (kind == 0) return 8'(i * 29 + len * 7 + 3);
    if (kind == 1) return 8'hFF;
    return 8'h7E;
  endfunction

  task automatic run_frame(input int len, input int kind, input bit bad, input int extra);
    logic [15:0] c;
    logic [7:0]  pay [8];
    string       tag;
    c = 16'hFFFF;
    for (int i = 0; i < len; i++) begin
      pay[i] = pay_of(kind, len, i);
      c = crc_upd(c, pay[i]);
    end
    c = ~c;
    if (bad) c[0] = ~c[0];
    out_n = 0;
    send_idle(8);
    send_flag();
    for (int i = 0; i < len; i++) send_byte(pay[i]);
    send_byte(c[7:0]);
    send_byte(c[15:8]);
    repeat (extra) send_data_bit(1'b0);
    send_flag();
    send_idle(8);
    if (extra > 0) begin
      // R8: misaligned bit count flagged on the closing byte
      chk(out_n > 0 && cap_e[out_n-1] && cap_r[out_n-1], "R8", out_n > 0 ? int'(cap_r[out_n-1]) : 0, 1);
    end else begin
      tag = (zero_len != OSR) ? "R9" : (kind == 0) ? "R1" : (kind == 1) ? "R2" : "R3";
      chk(out_n == len, "R4", out_n, len);
      if (out_n == len) begin
        for (int i = 0; i < len; i++) begin
          chk(cap_d[i] == pay[i], tag, cap_d[i], pay[i]);
          chk(cap_e[i] == (i == len - 1), "R5", cap_e[i], i == len - 1);
        end
        if (len > 0) chk(cap_r[len-1] == bad, "R6", cap_r[len-1], bad);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!valid && !eof && !err, "R10", {valid, eof, err}, 0);

    // R3: idle and repeated flags yield nothing
    out_n = 0;
    send_idle(20);
    repeat (4) send_flag();
    send_idle(10);
    chk(out_n == 0, "R3", out_n, 0);

    // R1 R2 R3 R4 R5 R6 R9: sweep bit timing, payload pattern and length
    for (int z = 0; z < 3; z++) begin
      zero_len = (z == 0) ? OSR : (z == 1) ? OSR - 1 : OSR + 1;
      for (int kind = 0; kind < 3; kind++)
        for (int len = 0; len < 6; len++)
          run_frame(len, kind, 1'b0, 0);
    end
    zero_len = OSR;

    // R6: corrupted check sequence
    run_frame(3, 0, 1'b1, 0);
    run_frame(1, 1, 1'b1, 0);

    // R8: stray bits before the closing flag
    run_frame(3, 0, 1'b0, 1);
    run_frame(2, 0, 1'b0, 3);

    // R7: abort after five bytes, two released, no end marker
    out_n = 0;
    send_idle(8);
    send_flag();
    for (int i = 0; i < 5; i++) send_byte(pay_of(0, 9, i));
    repeat (7) send_bit(1'b1);
    send_idle(8);
    chk(out_n == 2, "R7", out_n, 2);
    if (out_n == 2) begin
      chk(!cap_e[0] && !cap_e[1], "R7", cap_e[1], 0);
      chk(cap_d[0] == pay_of(0, 9, 0), "R7", cap_d[0], pay_of(0, 9, 0));
    end
    run_frame(4, 0, 1'b0, 0);

    summary();
    $finish;
  end
endmodule